// File: doc/BRIEF.md
# Capacitive Key Touch Decision Engine

This block makes the touch decision for every channel of a multi-key capacitive sensor. A measurement strobe delivers one new signal count per key. For each key the block keeps a baseline that stands for the untouched level. A touch raises the signal. A key is declared touched only after a run of consecutive measurements sits above the baseline plus a detect margin. A second run, below the margin minus a hysteresis band, declares the key released. Both margins are added to the live baseline, so they move whenever the baseline moves.

When no key is touched, each baseline creeps toward its signal one count at a time. Two shared timers set the pace, one for upward creep and one for downward creep. A second strobe that marks 160 ms time slots drives both timers, so a bench can shrink real time to a few clocks. Creep stops on every key while any key is touched. It stays stopped for a programmable number of slots after the last release. A calibration sequence copies each signal into its baseline over a fixed run of measurements. It runs once after reset and again whenever one is requested.

Top module: `keydet_core`

## Requirements
- R1: After reset, `cal_busy` is 1 and `detect` is all zeros. Reset starts a calibration sequence.
- R2: An enabled key that is not touched sets its `detect` bit after L consecutive measurements with signal > baseline + `thr_cnt`. L is the effective integrator length. A measurement that fails this test clears the run.
- R3: The effective length L equals `di_set`. A `di_set` of 0 gives 1. Any value above 32 gives 32.
- R4: A touched key clears its `detect` bit after L consecutive measurements with signal + `hyst_cnt` < baseline + `thr_cnt`. A measurement that fails this test clears the run.
- R5: A key with its `key_en` bit at 0 shows 0 on `detect` from the next clock on, and its run count is cleared.
- R6: When `cal_busy` is 0, `cal_req` raises `cal_busy` at the next clock. The sequence ends on the 15th measurement strobe after that, and every baseline then equals the signal of that strobe. While `cal_busy` is 1, `detect` reads 0 and `cal_req` is ignored.
- R7: When creep is allowed, every T slot strobes each enabled key whose signal is above its baseline has its baseline raised by 1. T is `up_rate`, or 1 if `up_rate` is 0.
- R8: When creep is allowed, every A slot strobes each enabled key whose signal is below its baseline has its baseline lowered by 1. A is `dn_rate`, or 1 if `dn_rate` is 0. A baseline never steps past its signal.
- R9: Creep is blocked while any `detect` bit is 1. After the last release it stays blocked until `hold_slots` slot strobes have passed. Both rate counts restart from zero whenever creep is blocked.
- R10: The detect and release levels are taken against the baseline as it stands after creep, not as it stood at calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_stb | input | 1 | New signal counts valid this cycle |
| slot_stb | input | 1 | One 160 ms time slot has elapsed |
| cal_req | input | 1 | Request a calibration sequence |
| sig_cnt | input | NKEYS*CW | Signal counts, key k at bits [k*CW +: CW] |
| key_en | input | NKEYS | Per-key enable, 1 = touch channel |
| thr_cnt | input | 8 | Detect margin above baseline |
| hyst_cnt | input | 8 | Release hysteresis below the detect margin |
| di_set | input | DIW | Integrator length setting |
| up_rate | input | TW | Slots per upward creep step |
| dn_rate | input | TW | Slots per downward creep step |
| hold_slots | input | TW | Slots of creep freeze after the last release |
| detect | output | NKEYS | Per-key touched flag |
| cal_busy | output | 1 | Calibration sequence in progress |

## Verification
The hardest case to reach from the ports is a release followed closely by an interrupted hold window. Here creep must stay frozen through a given number of slots, and then the two rate counts must restart from zero and not resume. To get there, the stimulus holds a touch while a neighbour key's signal sits off its baseline. It then releases the touch, sends slot strobes one at a time, and finally probes the shifted baseline with a signal placed one count either side of the new detect level. Random phases with short rate settings mix these events with calibration requests and enable toggles, and a bench model tracks every baseline.

// File: rtl/keydet_pkg.sv
package keydet_pkg;
  localparam int CAL_MEAS = 15;
  localparam int DI_MAX   = 32;
endpackage

// File: rtl/keydet_cal.sv
module keydet_cal #(
  parameter int MEAS_N = keydet_pkg::CAL_MEAS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic meas,
  input  logic req,
  output logic busy,
  output logic load
);
  localparam int CNTW = $clog2(MEAS_N) + 1;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            busy_d;

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    if (busy) begin
      if (meas) begin
        if (cnt_q == CNTW'(MEAS_N - 1)) begin
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end

  assign load = busy & meas;

  // R6
  cal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && meas && (cnt_q == CNTW'(MEAS_N - 1)) |=> !busy);
  // R6
  cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req |=> busy && (cnt_q == '0));
endmodule

// File: rtl/keydet_timebase.sv
module keydet_timebase #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot,
  input  logic          any_det,
  input  logic          cal_busy,
  input  logic [TW-1:0] up_rate,
  input  logic [TW-1:0] dn_rate,
  input  logic [TW-1:0] hold_slots,
  output logic          step_up,
  output logic          step_dn
);
  logic [TW-1:0] hold_q, hold_d, up_q, up_d, dn_q, dn_d;
  logic [TW-1:0] up_lim, dn_lim;
  logic          drift_ok;

  assign up_lim   = (up_rate == '0) ? TW'(1) : up_rate;
  assign dn_lim   = (dn_rate == '0) ? TW'(1) : dn_rate;
  assign drift_ok = !any_det && (hold_q == '0) && !cal_busy;

  always_comb begin
    hold_d  = hold_q;
    up_d    = up_q;
    dn_d    = dn_q;
    step_up = 1'b0;
    step_dn = 1'b0;
    if (cal_busy)                     hold_d = '0;
    else if (any_det)                 hold_d = hold_slots;
    else if (slot && hold_q != '0)    hold_d = hold_q - 1'b1;
    if (!drift_ok) begin
      up_d = '0;
      dn_d = '0;
    end else if (slot) begin
      if (({1'b0, up_q} + 1'b1) >= {1'b0, up_lim}) begin
        up_d    = '0;
        step_up = 1'b1;
      end else begin
        up_d = up_q + 1'b1;
      end
      if (({1'b0, dn_q} + 1'b1) >= {1'b0, dn_lim}) begin
        dn_d    = '0;
        step_dn = 1'b1;
      end else begin
        dn_d = dn_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      up_q   <= '0;
      dn_q   <= '0;
    end else begin
      hold_q <= hold_d;
      up_q   <= up_d;
      dn_q   <= dn_d;
    end
  end

  // R9
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |-> !(step_up || step_dn));
  // R9
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_det && !cal_busy |=> (hold_q == $past(hold_slots)));
endmodule

// File: rtl/keydet_chan.sv
module keydet_chan #(
  parameter int CW  = 12,
  parameter int DIW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           meas,
  input  logic           cal_busy,
  input  logic           cal_load,
  input  logic [CW-1:0]  sig,
  input  logic [7:0]     thr,
  input  logic [7:0]     hyst,
  input  logic [DIW-1:0] run_lim,
  input  logic           step_up,
  input  logic           step_dn,
  output logic           det
);
  localparam int EW = CW + 2;

  logic [CW-1:0]  base_q, base_d;
  logic [DIW-1:0] run_q, run_d;
  logic           det_d, above, below, hit;
  logic [EW-1:0]  on_lvl, sig_x;

  assign on_lvl = EW'(base_q) + EW'(thr);
  assign sig_x  = EW'(sig);
  assign above  = sig_x > on_lvl;
  assign below  = (sig_x + EW'(hyst)) < on_lvl;
  assign hit    = det ? below : above;

  always_comb begin
    base_d = base_q;
    run_d  = run_q;
    det_d  = det;
    if (cal_busy) begin
      det_d = 1'b0;
      run_d = '0;
      if (cal_load) base_d = sig;
    end else if (!en) begin
      det_d = 1'b0;
      run_d = '0;
    end else begin
      if (meas) begin
        if (hit) begin
          if (({1'b0, run_q} + 1'b1) >= {1'b0, run_lim}) begin
            det_d = !det;
            run_d = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end
      if (step_up && sig > base_q)      base_d = base_q + 1'b1;
      else if (step_dn && sig < base_q) base_d = base_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      run_q  <= '0;
      det    <= 1'b0;
    end else begin
      base_q <= base_d;
      run_q  <= run_d;
      det    <= det_d;
    end
  end

  // R5
  off_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !det);
  // R2
  det_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas && !cal_busy && en |=> $stable(det));
  // R6
  cal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |=> !det);
  // R8
  base_slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy |=> (base_q == $past(base_q)) || (base_q == $past(base_q) + 1'b1)
                  || (base_q == $past(base_q) - 1'b1));
endmodule

// File: rtl/keydet_core.sv
module keydet_core #(
  parameter int NKEYS = 4,
  parameter int CW    = 12,
  parameter int TW    = 8,
  parameter int DIW   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               meas_stb,
  input  logic               slot_stb,
  input  logic               cal_req,
  input  logic [NKEYS*CW-1:0] sig_cnt,
  input  logic [NKEYS-1:0]   key_en,
  input  logic [7:0]         thr_cnt,
  input  logic [7:0]         hyst_cnt,
  input  logic [DIW-1:0]     di_set,
  input  logic [TW-1:0]      up_rate,
  input  logic [TW-1:0]      dn_rate,
  input  logic [TW-1:0]      hold_slots,
  output logic [NKEYS-1:0]   detect,
  output logic               cal_busy
);
  localparam logic [DIW-1:0] DI_TOP = DIW'(keydet_pkg::DI_MAX);

  logic [DIW-1:0] run_lim;
  logic           cal_load, step_up, step_dn, any_det;

  assign run_lim = (di_set == '0) ? DIW'(1) : ((di_set > DI_TOP) ? DI_TOP : di_set);
  assign any_det = |detect;

  keydet_cal #(.MEAS_N(keydet_pkg::CAL_MEAS)) u_cal (
    .clk(clk), .rst_n(rst_n), .meas(meas_stb), .req(cal_req),
    .busy(cal_busy), .load(cal_load)
  );

  keydet_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .slot(slot_stb), .any_det(any_det),
    .cal_busy(cal_busy), .up_rate(up_rate), .dn_rate(dn_rate),
    .hold_slots(hold_slots), .step_up(step_up), .step_dn(step_dn)
  );

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    keydet_chan #(.CW(CW), .DIW(DIW)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(key_en[k]), .meas(meas_stb),
      .cal_busy(cal_busy), .cal_load(cal_load), .sig(sig_cnt[k*CW +: CW]),
      .thr(thr_cnt), .hyst(hyst_cnt), .run_lim(run_lim),
      .step_up(step_up), .step_dn(step_dn), .det(detect[k])
    );
  end

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_det |-> !(step_up || step_dn));
  // R3
  run_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lim != '0) && (run_lim <= DI_TOP));
endmodule

// File: tb/keydet_core_bench.sv
module keydet_core_bench;
  localparam int N = 4, CW = 12, TW = 8, DIW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n, meas_stb, slot_stb, cal_req, cal_busy;
  logic [N*CW-1:0]    sig_cnt;
  logic [N-1:0]       key_en, detect;
  logic [7:0]         thr_cnt, hyst_cnt;
  logic [DIW-1:0]     di_set;
  logic [TW-1:0]      up_rate, dn_rate, hold_slots;
  int                 sig_v [N];

  always_comb for (int k = 0; k < N; k++) sig_cnt[k*CW +: CW] = CW'(sig_v[k]);

  keydet_core #(.NKEYS(N), .CW(CW), .TW(TW), .DIW(DIW)) u_keydet_core (
    .clk(clk), .rst_n(rst_n), .meas_stb(meas_stb), .slot_stb(slot_stb),
    .cal_req(cal_req), .sig_cnt(sig_cnt), .key_en(key_en), .thr_cnt(thr_cnt),
    .hyst_cnt(hyst_cnt), .di_set(di_set), .up_rate(up_rate), .dn_rate(dn_rate),
    .hold_slots(hold_slots), .detect(detect), .cal_busy(cal_busy)
  );

  int    m_base [N], m_run [N];
  bit    m_det [N];
  bit    m_busy;
  int    m_ccnt, m_hold, m_up, m_dn;
  int    n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  function automatic int lim(input int v, input int hi);
    return (v == 0) ? 1 : ((v > hi) ? hi : v);
  endfunction

  task automatic model_edge(input bit meas, input bit slot, input bit creq);
    bit any, ok, up, dn, hit;
    int dil;
    if (m_busy) begin
      for (int k = 0; k < N; k++) begin
        m_det[k] = 0; m_run[k] = 0;
        if (meas) m_base[k] = sig_v[k];
      end
      m_hold = 0; m_up = 0; m_dn = 0;
      if (meas) begin
        m_ccnt++;
        if (m_ccnt == 15) begin m_busy = 0; m_ccnt = 0; end
      end
      return;
    end
    any = 0;
    for (int k = 0; k < N; k++) any |= m_det[k];
    ok = !any && (m_hold == 0);
    up = 0; dn = 0;
    dil = lim(int'(di_set), 32);
    if (!ok) begin m_up = 0; m_dn = 0; end
    else if (slot) begin
      if (m_up + 1 >= lim(int'(up_rate), 1 << 30)) begin m_up = 0; up = 1; end else m_up++;
      if (m_dn + 1 >= lim(int'(dn_rate), 1 << 30)) begin m_dn = 0; dn = 1; end else m_dn++;
    end
    if (any) m_hold = int'(hold_slots);
    else if (slot && m_hold != 0) m_hold--;
    for (int k = 0; k < N; k++) begin
      if (!key_en[k]) begin m_det[k] = 0; m_run[k] = 0; end
      else begin
        if (meas) begin
          hit = m_det[k] ? (sig_v[k] + int'(hyst_cnt) < m_base[k] + int'(thr_cnt))
                         : (sig_v[k] > m_base[k] + int'(thr_cnt));
          if (hit) begin
            if (m_run[k] + 1 >= dil) begin m_det[k] = !m_det[k]; m_run[k] = 0; end
            else m_run[k]++;
          end else m_run[k] = 0;
        end
        if (up && sig_v[k] > m_base[k]) m_base[k]++;
        else if (dn && sig_v[k] < m_base[k]) m_base[k]--;
      end
    end
    if (creq) begin m_busy = 1; m_ccnt = 0; end
  endtask

  task automatic compare();
    logic [N-1:0] exp_det;
    for (int k = 0; k < N; k++) exp_det[k] = m_det[k];
    n_chk++;
    if (detect !== exp_det || cal_busy !== m_busy) begin
      n_bad++;
      $display("FAIL %s: detect=%b cal_busy=%b expected detect=%b cal_busy=%b at %0t",
               tag, detect, cal_busy, exp_det, m_busy, $time);
    end
  endtask

  task automatic step(input bit meas, input bit slot, input bit creq);
    @(negedge clk);
    meas_stb = meas; slot_stb = slot; cal_req = creq;
    model_edge(meas, slot, creq);
    @(posedge clk);
    #1;
    compare();
    meas_stb = 0; slot_stb = 0; cal_req = 0;
  endtask

  task automatic meas_n(input int n);
    for (int i = 0; i < n; i++) begin step(1, 0, 0); step(0, 0, 0); end
  endtask

  task automatic slot_n(input int n);
    for (int i = 0; i < n; i++) step(0, 1, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; meas_stb = 0; slot_stb = 0; cal_req = 0;
    key_en = '1; thr_cnt = 10; hyst_cnt = 3; di_set = 4;
    up_rate = 20; dn_rate = 5; hold_slots = 25;
    for (int k = 0; k < N; k++) begin
      sig_v[k] = 100 + 50 * k; m_base[k] = 0; m_run[k] = 0; m_det[k] = 0;
    end
    m_busy = 1; m_ccnt = 0; m_hold = 0; m_up = 0; m_dn = 0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1"; compare();
    @(negedge clk); rst_n = 1;

    // R6: power-up calibration, 15 strobes; requests during it are ignored
    tag = "R6";
    step(0, 0, 1);
    meas_n(14);
    step(0, 0, 1);
    meas_n(1);
    step(0, 0, 0);

    // R2: run of 4 needed, broken run restarts, equal level never counts
    tag = "R2";
    sig_v[0] = 111; sig_v[1] = 160;
    meas_n(3);
    sig_v[0] = 110; meas_n(1);
    sig_v[0] = 111; meas_n(3);
    meas_n(1);

    // R9: key 0 held, key 2 off baseline, slots must not move anything
    tag = "R9";
    sig_v[2] = 190; up_rate = 1; dn_rate = 1; hold_slots = 3;
    slot_n(6);

    // R4: release needs signal + hyst below level on 4 runs
    tag = "R4";
    sig_v[0] = 108; meas_n(5);
    sig_v[0] = 106; meas_n(3);
    sig_v[0] = 108; meas_n(1);
    sig_v[0] = 106; meas_n(4);

    // R9: hold window then rate restart
    tag = "R9";
    slot_n(2); step(0, 0, 0); slot_n(1);

    // R7, R8: creep both ways with different rates
    tag = "R7";
    up_rate = 2; dn_rate = 3;
    sig_v[1] = 170; sig_v[2] = 195;
    slot_n(8);
    tag = "R8";
    slot_n(9);

    // R10: probe moved baseline with single-run detection
    tag = "R10";
    di_set = 1; up_rate = 200; dn_rate = 200;
    sig_v[1] = m_base[1] + 10; meas_n(1);
    sig_v[1] = m_base[1] + 11; meas_n(1);
    sig_v[1] = m_base[1]; meas_n(1);

    // R3: zero acts as 1, above 32 acts as 32
    tag = "R3";
    di_set = 0; sig_v[3] = m_base[3] + 20; meas_n(1);
    sig_v[3] = m_base[3]; meas_n(1);
    di_set = 40; sig_v[3] = m_base[3] + 20; meas_n(31);
    meas_n(1);
    sig_v[3] = m_base[3]; di_set = 1; meas_n(1);

    // R5: disabled key never reports, and loses its run
    tag = "R5";
    di_set = 2; sig_v[2] = m_base[2] + 30;
    meas_n(1); key_en[2] = 0; meas_n(3);
    key_en[2] = 1; meas_n(1); meas_n(1);
    sig_v[2] = m_base[2]; meas_n(2);

    // R6: request while idle, new baselines
    tag = "R6";
    for (int k = 0; k < N; k++) sig_v[k] = 300 + 7 * k;
    step(0, 0, 1);
    meas_n(15);
    sig_v[0] = 311; di_set = 1; meas_n(1);
    sig_v[0] = 300; meas_n(1);

    // R10: random mix
    tag = "R10";
    up_rate = 2; dn_rate = 1; hold_slots = 2; di_set = 2;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0)
        for (int k = 0; k < N; k++) begin
          sig_v[k] = m_base[k] + int'($urandom_range(0, 30)) - 12;
          if (sig_v[k] < 0) sig_v[k] = 0;
        end
      if ($urandom_range(0, 199) == 0) key_en = N'($urandom);
      if ($urandom_range(0, 299) == 0) di_set = DIW'($urandom_range(0, 5));
      if ($urandom_range(0, 299) == 0) hold_slots = TW'($urandom_range(0, 4));
      if ($urandom_range(0, 299) == 0) up_rate = TW'($urandom_range(0, 3));
      step(bit'($urandom_range(0, 2) == 0), bit'($urandom_range(0, 3) == 0),
           bit'($urandom_range(0, 399) == 0));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule